// File: doc/BRIEF.md
# Split-Word 64-bit Register Bridge

This block lets a 32-bit request interface reach 64-bit internal registers. Each 64-bit register takes two neighbouring 32-bit word addresses. The even (lower) word address holds bits 63..32 and the odd (higher) word address holds bits 31..0. Writes are two-step. A write to an even word only loads a single shared staging register. A write to the odd word then commits `{staging, write data}` in one step. If software writes only the odd word, the upper half comes from whatever is staged, which is zero after reset.

The bridge holds two registers. Register 0 is a read/write configuration register. Bit 31 of its odd word is a self-clearing software-reset request. Register 1 is a read-only 64-bit event counter. A small state machine, with states SNAP_IDLE and SNAP_HELD, keeps two-read accesses to the live counter coherent:
- Reading the even counter word takes the transition CAPTURE (SNAP_IDLE or SNAP_HELD to SNAP_HELD). This snapshots the whole count.
- The next odd-word read returns the snapshot's low half and takes the transition RELEASE (SNAP_HELD to SNAP_IDLE).
- An odd-word read in SNAP_IDLE takes the transition PASS (SNAP_IDLE to SNAP_IDLE) and returns the live low bits.

A read request is answered one cycle later with a response strobe and data.

Top module: `split_reg_bridge`

## Requirements
- R1: After reset, `cfg_value` is 0, `rsp_valid` is 0, `sw_reset_pulse` is 0, the counter equals parameter CNT_INIT and the snapshot machine is in SNAP_IDLE.
- R2: Word address 2k reads bits 63..32 of register k and word address 2k+1 reads bits 31..0. Register 0 is the configuration register and register 1 is the counter. Every other address reads as 0, and an odd-address write there changes nothing.
- R3: A write to any even word address only loads the staging register. `cfg_value` is unchanged.
- R4: A write to word address 1 sets `cfg_value` to `{staging, wdata}` at the clock edge of the request, with bit 31 forced to 0. Staging keeps its value, so a write to the odd word alone reuses it.
- R5: A later even-word write replaces an uncommitted staged value.
- R6: A word-1 write with wdata bit 31 = 1 drives `sw_reset_pulse` high for exactly the cycle after the write. That bit is never stored and reads back as 0.
- R7: A read request at one clock edge gives `rsp_valid` = 1 with `rsp_rdata` during the following cycle. A write request gives no response.
- R8: A read of word address 2 returns the live counter bits 63..32 and snapshots all 64 bits (CAPTURE). The next read of word 3 returns the snapshot's bits 31..0, whatever events occurred in between (RELEASE).
- R9: A read of word 3 in SNAP_IDLE returns the live counter bits 31..0 (PASS).
- R10: The counter adds 1 at every clock edge where `evt_strobe` is 1 and wraps from all ones to 0.
- R11: Writes to the counter's words never change the counter. An even-word write there still loads the shared staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | 32-bit word address |
| req_wdata | input | 32 | Write data |
| evt_strobe | input | 1 | Counter increment event |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| cfg_value | output | 64 | Committed configuration register |
| sw_reset_pulse | output | 1 | One-cycle software-reset request |

## Verification
Every result is due exactly one clock edge after the request that causes it:
- `cfg_value`, the staging register, the counter and the snapshot state change at the edge that samples the request.
- `rsp_valid`, `rsp_rdata` and `sw_reset_pulse` are valid for the whole following cycle.

The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares all outputs on the next falling edge, so each value is sampled in the one cycle it is due. Directed reads sample `rsp_rdata` on the falling edge right after the request edge. The pulse is checked in that cycle and in the cycle after.

// File: rtl/split_bridge_pkg.sv
package split_bridge_pkg;
    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_t;
endpackage

// File: rtl/bridge_stage_unit.sv
module bridge_stage_unit #(
    parameter int DW        = 32,
    parameter int RESET_BIT = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stage_we,
    input  logic            commit_we,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cfg_q,
    output logic            reset_pulse
);
    logic [DW-1:0] stage_q;
    logic [DW-1:0] low_masked;

    always_comb begin
        low_masked            = wdata;
        low_masked[RESET_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q     <= '0;
            cfg_q       <= '0;
            reset_pulse <= 1'b0;
        end else begin
            reset_pulse <= commit_we & wdata[RESET_BIT];
            if (stage_we)
                stage_q <= wdata;
            if (commit_we)
                cfg_q <= {stage_q, low_masked};
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_we |=> $stable(cfg_q));
    // R5
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_we |=> stage_q == $past(wdata));
endmodule

// File: rtl/bridge_event_counter.sv
module bridge_event_counter #(
    parameter int             CW   = 64,
    parameter logic [CW-1:0]  INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= INIT;
        else if (evt)
            count <= count + CW'(1);
    end

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(count));
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/bridge_snap_reader.sv
module bridge_snap_reader
    import split_bridge_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_upper,
    input  logic            rd_lower,
    input  logic [2*DW-1:0] live,
    output logic [DW-1:0]   lower_data
);
    snap_state_t     state_q, state_d;
    logic [2*DW-1:0] snap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (rd_upper) state_d = SNAP_HELD;
            SNAP_HELD: begin
                if (rd_upper)      state_d = SNAP_HELD;
                else if (rd_lower) state_d = SNAP_IDLE;
            end
            default:   state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_upper)
                snap_q <= live;
        end
    end

    always_comb begin
        unique case (state_q)
            SNAP_HELD: lower_data = snap_q[DW-1:0];
            default:   lower_data = live[DW-1:0];
        endcase
    end

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_upper |=> state_q == SNAP_HELD && snap_q == $past(live));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lower && !rd_upper) |=> state_q == SNAP_IDLE);
endmodule

// File: rtl/split_reg_bridge.sv
module split_reg_bridge #(
    parameter int               ADDR_W   = 3,
    parameter logic [63:0]      CNT_INIT = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              evt_strobe,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [63:0]       cfg_value,
    output logic              sw_reset_pulse
);
    localparam int               DW      = 32;
    localparam int               IDX_W   = ADDR_W - 1;
    localparam logic [IDX_W-1:0] IDX_CFG = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_CNT = IDX_W'(1);

    logic [IDX_W-1:0] reg_idx;
    logic             low_half;
    logic             is_wr, is_rd;
    logic [2*DW-1:0]  cnt_value;
    logic [DW-1:0]    cnt_lower;
    logic [DW-1:0]    rd_mux;

    assign reg_idx  = req_addr[ADDR_W-1:1];
    assign low_half = req_addr[0];
    assign is_wr    = req_valid & req_write;
    assign is_rd    = req_valid & ~req_write;

    bridge_stage_unit #(.DW(DW), .RESET_BIT(31)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_we   (is_wr & ~low_half),
        .commit_we  (is_wr & low_half & (reg_idx == IDX_CFG)),
        .wdata      (req_wdata),
        .cfg_q      (cfg_value),
        .reset_pulse(sw_reset_pulse)
    );

    bridge_event_counter #(.CW(2*DW), .INIT(CNT_INIT)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt_strobe),
        .count(cnt_value)
    );

    bridge_snap_reader #(.DW(DW)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_upper  (is_rd & ~low_half & (reg_idx == IDX_CNT)),
        .rd_lower  (is_rd &  low_half & (reg_idx == IDX_CNT)),
        .live      (cnt_value),
        .lower_data(cnt_lower)
    );

    always_comb begin
        rd_mux = '0;
        if (reg_idx == IDX_CFG)
            rd_mux = low_half ? cfg_value[DW-1:0] : cfg_value[2*DW-1:DW];
        else if (reg_idx == IDX_CNT)
            rd_mux = low_half ? cnt_lower : cnt_value[2*DW-1:DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= is_rd;
            if (is_rd)
                rsp_rdata <= rd_mux;
        end
    end

    // R7
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(is_rd));
    // R6
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset_pulse |-> $past(is_wr && low_half && reg_idx == IDX_CFG && req_wdata[31]));
    // R6
    pulse_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr) == ADDR_W'(1)) |-> !rsp_rdata[31]);
endmodule

// File: tb/test_split_reg_bridge.sv
`timescale 1ns/1ps
module test_split_reg_bridge;
    localparam logic [63:0] INIT = 64'hFFFF_FFFF_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, evt_strobe = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, sw_reset_pulse;
    logic [31:0] rsp_rdata;
    logic [63:0] cfg_value;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    split_reg_bridge #(.ADDR_W(3), .CNT_INIT(INIT)) i_split_reg_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .evt_strobe(evt_strobe),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_value(cfg_value),
        .sw_reset_pulse(sw_reset_pulse));

    // behavioural reference
    logic [63:0] m_cnt, m_cfg, m_snap;
    logic [31:0] m_stage, m_rd;
    logic        m_held, m_rv, m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= INIT; m_cfg <= 0; m_snap <= 0; m_stage <= 0;
            m_rd <= 0; m_held <= 0; m_rv <= 0; m_pulse <= 0;
        end else begin
            m_rv <= 0; m_pulse <= 0;
            if (req_valid && req_write) begin
                if (!req_addr[0]) m_stage <= req_wdata;
                else if (req_addr[2:1] == 0) begin
                    m_cfg   <= {m_stage, req_wdata & 32'h7FFF_FFFF};
                    m_pulse <= req_wdata[31];
                end
            end else if (req_valid) begin
                m_rv <= 1;
                case (req_addr[2:1])
                    0: m_rd <= req_addr[0] ? m_cfg[31:0] : m_cfg[63:32];
                    1: if (!req_addr[0]) begin
                           m_rd <= m_cnt[63:32]; m_snap <= m_cnt; m_held <= 1;
                       end else begin
                           m_rd <= m_held ? m_snap[31:0] : m_cnt[31:0]; m_held <= 0;
                       end
                    default: m_rd <= 0;
                endcase
            end
            if (evt_strobe) m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        check("R7 rsp_valid per-cycle", rsp_valid, m_rv);
        if (m_rv) check("R2/R8/R9 rsp_rdata per-cycle", rsp_rdata, m_rd);
        check("R4 cfg_value per-cycle", cfg_value, m_cfg);
        check("R6 pulse per-cycle", sw_reset_pulse, m_pulse);
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk); req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk); req_valid = 0; d = rsp_rdata;
    endtask

    task automatic events(input int n);
        @(negedge clk); evt_strobe = 1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); evt_strobe = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 cfg reset", cfg_value, 0);
        check("R1 rsp_valid reset", rsp_valid, 0);
        check("R1 pulse reset", sw_reset_pulse, 0);
        // R9 live low in idle
        rd(3'd3, d); check("R9 live low", d, 32'hFFFF_FFF0);
        // R8 capture then events then snapshot low
        rd(3'd2, d); check("R8 upper", d, 32'hFFFF_FFFF);
        events(5);
        rd(3'd3, d); check("R8 snapshot low", d, 32'hFFFF_FFF0);
        rd(3'd3, d); check("R9 live after release", d, 32'hFFFF_FFF5);
        // R3
        wr(3'd0, 32'hA5A5_0001);
        check("R3 stage only", cfg_value, 0);
        rd(3'd0, d); check("R3 readback", d, 0);
        // R4
        wr(3'd1, 32'h0000_1234);
        check("R4 commit", cfg_value, 64'hA5A5_0001_0000_1234);
        rd(3'd0, d); check("R4 read upper", d, 32'hA5A5_0001);
        rd(3'd1, d); check("R4 read lower", d, 32'h0000_1234);
        wr(3'd1, 32'h0000_00FF);
        check("R4 odd-only reuses stage", cfg_value, 64'hA5A5_0001_0000_00FF);
        // R5
        wr(3'd0, 32'h1111_1111); wr(3'd0, 32'h2222_2222); wr(3'd1, 32'h5);
        check("R5 overwrite stage", cfg_value, 64'h2222_2222_0000_0005);
        // R6
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h8000_0000);
        check("R6 pulse high", sw_reset_pulse, 1);
        @(negedge clk); check("R6 pulse low", sw_reset_pulse, 0);
        check("R6 bit cleared", cfg_value, 0);
        rd(3'd1, d); check("R6 reads 0", d, 0);
        wr(3'd1, 32'h8000_0007);
        check("R6 single write pulse", sw_reset_pulse, 1);
        check("R6 single write cfg", cfg_value, 64'h7);
        // R10 wrap: count at ...F5, 11 events -> 0
        events(11);
        rd(3'd2, d); check("R10 wrap upper", d, 0);
        rd(3'd3, d); check("R10 wrap lower", d, 0);
        events(3);
        rd(3'd3, d); check("R10 increment", d, 3);
        // R11
        wr(3'd2, 32'hDEAD_0000); wr(3'd3, 32'hBEEF);
        rd(3'd2, d); check("R11 counter upper untouched", d, 0);
        rd(3'd3, d); check("R11 counter lower untouched", d, 3);
        check("R11 cfg untouched", cfg_value, 64'h7);
        wr(3'd1, 32'h1);
        check("R11 shared stage", cfg_value, 64'hDEAD_0000_0000_0001);
        // R2
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h9);
        check("R2 unmapped write", cfg_value, 64'hDEAD_0000_0000_0001);
        rd(3'd5, d); check("R2 unmapped read", d, 0);
        rd(3'd6, d); check("R2 unmapped read even", d, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule